// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block drives the complete bus sequence for one NAND flash page read or page program without software stepping through it. A host presents a page number, a chip-select index, the direction, a raw-mode flag, the bus width, a large-device flag and the sector count, then pulses start. The sequencer issues the opcode, the column and row address bytes and the optional confirm opcode. It waits on the ready/busy line where the device needs time, then moves the sector payload through a streaming port. Unless raw mode is selected, it then issues a column-change command to the spare area and moves the ECC bytes found there.

Every configuration input is captured when the start pulse is accepted. Commands and addresses always travel as bytes on the low data lane. On a 16-bit device, only the data phases widen to 16 bits. The spare-area column is fixed by two parameters, the page data size and the bad-block-marker length, and is halved on a 16-bit bus because that bus counts columns in words.

Top module: `nand_page_seq`

## Requirements
- R1: While reset is held, and after it is released, busy_o and done_o are low, every ce_n_o bit is high, we_n_o and re_n_o are high, cle_o, ale_o and dq_oe_o are low, and rd_valid_o is low.
- R2: A read issues opcode 0x00, then the address bytes, then opcode 0x30. It then waits on the ready/busy line, and after that reads the sector data. Each read word is captured at the rising edge of re_n_o and presented on rd_data_o for one cycle, qualified by rd_valid_o. While re_n_o is low, dq_oe_o is low.
- R3: A program issues opcode 0x80, then the address bytes, then the sector data, then the spare step unless raw, and finally opcode 0x10. It then waits on the ready/busy line before done_o.
- R4: Address bytes are latched on the rising edge of we_n_o with ale_o high. Bytes one and two are 0x00, byte three is page[7:0] and byte four is page[15:8]. When big_dev_i is high, a fifth byte carries page[23:16]; otherwise only four bytes are sent.
- R5: Unless raw, after the sector data a read issues 0x05, two column bytes and 0xE0, and a program issues 0x85 and two column bytes. The column is PAGE_BYTES+BBM_BYTES, halved when bus16_i is high, with the low byte sent first.
- R6: The data phase moves (sectors_m1_i+1) sectors. A sector is SECTOR_BYTES words on an 8-bit bus and SECTOR_BYTES/2 words on a 16-bit bus.
- R7: Unless raw, the spare phase moves ECC_BYTES words on an 8-bit bus, or ECC_BYTES/2 words on a 16-bit bus, with ecc_phase_o high. With raw_i high, the column-change commands and the spare words are left out.
- R8: After opcode 0x30 or 0x10, the sequencer waits for rb_i to fall and then to rise. It pulses no strobe while rb_i is low, and done_o only follows a high rb_i.
- R9: During command and address cycles, dq_o[15:8] is zero and wid16_o is low. During data cycles, wid16_o equals the captured bus16_i. On an 8-bit bus, the upper byte of both written and read data is forced to zero.
- R10: While busy, only ce_n_o[cs] is low, where cs is the captured cs_i. While idle, all bits are high.
- R11: A start_i pulse while busy is ignored, and so are changes to the configuration inputs while busy: the ongoing bus sequence and chip select are unchanged.
- R12: done_o is a single-cycle pulse in the first idle cycle, with busy_o low. A start_i in that same cycle is accepted, and busy_o is high in the next cycle.
- R13: Each written word is taken from wr_data_i on a cycle with wr_valid_i and wr_ready_o both high. No we_n_o strobe for data happens until a word has been taken, and every word appears on the bus exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| write_i | input | 1 | 1 = program, 0 = read |
| raw_i | input | 1 | Skip the spare-area ECC step |
| bus16_i | input | 1 | Device has a 16-bit data bus |
| big_dev_i | input | 1 | Device needs three row bytes (above 128 MiB) |
| sectors_m1_i | input | SEC_W | Sector count minus one |
| page_i | input | 24 | Page number |
| cs_i | input | CS_W | Chip-select index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ce_n_o | output | NUM_CS | Chip enables, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| dq_o | output | 16 | Data bus out |
| dq_i | input | 16 | Data bus in |
| dq_oe_o | output | 1 | Data bus output enable |
| rb_i | input | 1 | Ready/busy, low = busy |
| wid16_o | output | 1 | Current cycle uses the 16-bit lane |
| wr_data_i | input | 16 | Write payload word |
| wr_valid_i | input | 1 | Write payload valid |
| wr_ready_o | output | 1 | Sequencer takes a write word |
| rd_data_o | output | 16 | Read payload word |
| rd_valid_o | output | 1 | Read payload valid |
| ecc_phase_o | output | 1 | Current data word belongs to the spare area |

## Verification
Completion and a new start can fall in the same cycle. In the bench, a program is launched in the very cycle where done_o of a raw read is seen. The bench then expects busy_o high one cycle later and the full program sequence on the pins, with no lost or repeated opcode. A stalled write stream can also coincide with the point where the sector data ends and the column-change command begins. A write that runs with wr_valid_i dropping on a fixed rhythm is judged by the cycle-by-cycle model, which requires every payload word exactly once and in order before the 0x85 opcode.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_WAIT_LO, ST_WAIT_HI,
    ST_DATA, ST_RCMD1, ST_RADDR, ST_RCMD2, ST_SPARE, ST_PCMD
  } seq_st_e;

  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READ_GO   = 8'h30;
  localparam logic [7:0] OP_PROG      = 8'h80;
  localparam logic [7:0] OP_PROG_GO   = 8'h10;
  localparam logic [7:0] OP_RCOL      = 8'h05;
  localparam logic [7:0] OP_RCOL_GO   = 8'hE0;
  localparam logic [7:0] OP_WCOL      = 8'h85;
endpackage

// File: rtl/nand_addr_sel.sv
module nand_addr_sel #(
  parameter int PAGE_BYTES = 2048,
  parameter int BBM_BYTES  = 2
) (
  input  logic        col_sel_i,
  input  logic [2:0]  idx_i,
  input  logic [23:0] page_i,
  input  logic        bus16_i,
  output logic [7:0]  byte_o
);
  localparam int         SPARE_OFF = PAGE_BYTES + BBM_BYTES;
  localparam logic [15:0] OFF_B8   = 16'(SPARE_OFF);
  localparam logic [15:0] OFF_B16  = 16'(SPARE_OFF / 2);

  logic [15:0] col;

  always_comb begin
    col = bus16_i ? OFF_B16 : OFF_B8;
    if (col_sel_i) begin
      byte_o = idx_i[0] ? col[15:8] : col[7:0];
    end else begin
      case (idx_i)
        3'd2:    byte_o = page_i[7:0];
        3'd3:    byte_o = page_i[15:8];
        3'd4:    byte_o = page_i[23:16];
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nand_word_cnt.sv
module nand_word_cnt #(
  parameter int WCNT_W = 10,
  parameter int UNIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [WCNT_W-1:0] words_i,
  input  logic [UNIT_W-1:0] units_m1_i,
  output logic              last_o
);
  logic [WCNT_W-1:0] word_q;
  logic [UNIT_W-1:0] unit_q;
  logic              wlast;

  assign wlast  = (word_q == words_i - WCNT_W'(1));
  assign last_o = wlast && (unit_q == units_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      unit_q <= '0;
    end else if (clr_i || (step_i && last_o)) begin
      word_q <= '0;
      unit_q <= '0;
    end else if (step_i) begin
      if (wlast) begin
        word_q <= '0;
        unit_q <= unit_q + UNIT_W'(1);
      end else begin
        word_q <= word_q + WCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_BYTES   = 2048,
  parameter int BBM_BYTES    = 2,
  parameter int ECC_BYTES    = 56,
  parameter int MAX_SECTORS  = 16,
  parameter int NUM_CS       = 2,
  localparam int SEC_W = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              raw_i,
  input  logic              bus16_i,
  input  logic              big_dev_i,
  input  logic [SEC_W-1:0]  sectors_m1_i,
  input  logic [23:0]       page_i,
  input  logic [CS_W-1:0]   cs_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NUM_CS-1:0] ce_n_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic [15:0]       dq_o,
  input  logic [15:0]       dq_i,
  output logic              dq_oe_o,
  input  logic              rb_i,
  output logic              wid16_o,
  input  logic [15:0]       wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              ecc_phase_o
);
  localparam int MAX_WORDS = (SECTOR_BYTES > ECC_BYTES) ? SECTOR_BYTES : ECC_BYTES;
  localparam int WCNT_W    = $clog2(MAX_WORDS + 1);
  localparam logic [WCNT_W-1:0] SEC_N8  = WCNT_W'(SECTOR_BYTES);
  localparam logic [WCNT_W-1:0] SEC_N16 = WCNT_W'(SECTOR_BYTES / 2);
  localparam logic [WCNT_W-1:0] ECC_N8  = WCNT_W'(ECC_BYTES);
  localparam logic [WCNT_W-1:0] ECC_N16 = WCNT_W'(ECC_BYTES / 2);

  seq_st_e          st_q;
  logic [1:0]       ph_q;
  logic [2:0]       idx_q;
  logic             wr_q, raw_q, b16_q, big_q, fin_q;
  logic [SEC_W-1:0] sec_q;
  logic [23:0]      page_q;
  logic [CS_W-1:0]  cs_q;
  logic [15:0]      wdat_q, rd_q;
  logic             rdv_q, done_q;

  logic             is_data, is_wdata, is_cmd, is_addr, beat_end, strobe_lo;
  logic             addr_last, cnt_last, cnt_step;
  logic [7:0]       op, abyte;
  logic [WCNT_W-1:0] words;
  logic [SEC_W-1:0] units_m1;

  assign is_data   = (st_q == ST_DATA) || (st_q == ST_SPARE);
  assign is_wdata  = is_data && wr_q;
  assign is_cmd    = (st_q == ST_CMD1) || (st_q == ST_CMD2) || (st_q == ST_RCMD1) ||
                     (st_q == ST_RCMD2) || (st_q == ST_PCMD);
  assign is_addr   = (st_q == ST_ADDR) || (st_q == ST_RADDR);
  // write data beat: fetch, strobe low, strobe high; all others: low, high
  assign beat_end  = is_wdata ? (ph_q == 2'd2) : (ph_q == 2'd1);
  assign strobe_lo = is_wdata ? (ph_q == 2'd1) : (ph_q == 2'd0);
  assign addr_last = (st_q == ST_RADDR) ? (idx_q == 3'd1) : (idx_q == (big_q ? 3'd4 : 3'd3));

  always_comb begin
    case (st_q)
      ST_CMD1:  op = wr_q ? OP_PROG : OP_READ;
      ST_CMD2:  op = OP_READ_GO;
      ST_RCMD1: op = wr_q ? OP_WCOL : OP_RCOL;
      ST_RCMD2: op = OP_RCOL_GO;
      ST_PCMD:  op = OP_PROG_GO;
      default:  op = 8'h00;
    endcase
  end

  nand_addr_sel #(.PAGE_BYTES(PAGE_BYTES), .BBM_BYTES(BBM_BYTES)) u_addr (
    .col_sel_i (st_q == ST_RADDR),
    .idx_i     (idx_q),
    .page_i    (page_q),
    .bus16_i   (b16_q),
    .byte_o    (abyte)
  );

  assign words    = (st_q == ST_SPARE) ? (b16_q ? ECC_N16 : ECC_N8) : (b16_q ? SEC_N16 : SEC_N8);
  assign units_m1 = (st_q == ST_SPARE) ? '0 : sec_q;
  assign cnt_step = is_data && beat_end;

  nand_word_cnt #(.WCNT_W(WCNT_W), .UNIT_W(SEC_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (st_q == ST_IDLE),
    .step_i     (cnt_step),
    .words_i    (words),
    .units_m1_i (units_m1),
    .last_o     (cnt_last)
  );

  // pin outputs
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign cle_o       = is_cmd;
  assign ale_o       = is_addr;
  assign we_n_o      = !((is_cmd || is_addr || is_wdata) && strobe_lo);
  assign re_n_o      = !(is_data && !wr_q && (ph_q == 2'd0));
  assign dq_oe_o     = is_cmd || is_addr || is_wdata;
  assign wid16_o     = is_data && b16_q;
  assign wr_ready_o  = is_wdata && (ph_q == 2'd0);
  assign rd_data_o   = rd_q;
  assign rd_valid_o  = rdv_q;
  assign ecc_phase_o = (st_q == ST_SPARE);

  always_comb begin
    if (is_cmd)        dq_o = {8'h00, op};
    else if (is_addr)  dq_o = {8'h00, abyte};
    else if (is_wdata) dq_o = b16_q ? wdat_q : {8'h00, wdat_q[7:0]};
    else               dq_o = 16'h0000;
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_ce
    assign ce_n_o[k] = !(busy_o && (cs_q == CS_W'(k)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= '0; idx_q <= '0;
      wr_q <= 1'b0; raw_q <= 1'b0; b16_q <= 1'b0; big_q <= 1'b0; fin_q <= 1'b0;
      sec_q <= '0; page_q <= '0; cs_q <= '0;
      wdat_q <= '0; rd_q <= '0; rdv_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (is_data && !wr_q && (ph_q == 2'd0)) begin
        rd_q  <= b16_q ? dq_i : {8'h00, dq_i[7:0]};
        rdv_q <= 1'b1;
      end
      case (st_q)
        ST_IDLE: if (start_i) begin
          wr_q <= write_i; raw_q <= raw_i; b16_q <= bus16_i; big_q <= big_dev_i;
          sec_q <= sectors_m1_i; page_q <= page_i; cs_q <= cs_i;
          fin_q <= 1'b0; ph_q <= '0; idx_q <= '0;
          st_q <= ST_CMD1;
        end
        ST_WAIT_LO: if (!rb_i) st_q <= ST_WAIT_HI;
        ST_WAIT_HI: if (rb_i) begin
          if (fin_q) begin
            st_q <= ST_IDLE; done_q <= 1'b1;
          end else begin
            st_q <= ST_DATA;
          end
        end
        default: begin
          if (is_wdata && (ph_q == 2'd0)) begin
            if (wr_valid_i) begin
              wdat_q <= wr_data_i;
              ph_q   <= 2'd1;
            end
          end else if (!beat_end) begin
            ph_q <= ph_q + 2'd1;
          end else begin
            ph_q <= '0;
            case (st_q)
              ST_CMD1: begin st_q <= ST_ADDR; idx_q <= '0; end
              ST_ADDR: begin
                if (addr_last) begin
                  idx_q <= '0;
                  st_q  <= wr_q ? ST_DATA : ST_CMD2;
                end else begin
                  idx_q <= idx_q + 3'd1;
                end
              end
              ST_CMD2: st_q <= ST_WAIT_LO;
              ST_DATA: if (cnt_last) begin
                if (!raw_q)    st_q <= ST_RCMD1;
                else if (wr_q) st_q <= ST_PCMD;
                else begin st_q <= ST_IDLE; done_q <= 1'b1; end
              end
              ST_RCMD1: begin st_q <= ST_RADDR; idx_q <= '0; end
              ST_RADDR: begin
                if (addr_last) begin
                  idx_q <= '0;
                  st_q  <= wr_q ? ST_SPARE : ST_RCMD2;
                end else begin
                  idx_q <= idx_q + 3'd1;
                end
              end
              ST_RCMD2: st_q <= ST_SPARE;
              ST_SPARE: if (cnt_last) begin
                if (wr_q) st_q <= ST_PCMD;
                else begin st_q <= ST_IDLE; done_q <= 1'b1; end
              end
              ST_PCMD: begin st_q <= ST_WAIT_LO; fin_q <= 1'b1; end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [NUM_CS-1:0] ce_n_o,
  input logic              cle_o,
  input logic              ale_o,
  input logic              we_n_o,
  input logic              re_n_o,
  input logic [15:0]       dq_o,
  input logic              dq_oe_o,
  input logic              rb_i,
  input logic              wid16_o
);
  p_ce_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_n_o) <= 1);
  p_ce_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> &ce_n_o);
  p_ce_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ce_n_o));
  p_rb_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_i |-> (we_n_o && re_n_o));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_lane_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o || ale_o) |-> (dq_o[15:8] == 8'h00 && !wid16_o && dq_oe_o));
  p_cle_ale_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_read_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_n_o |-> (!dq_oe_o && we_n_o));
endmodule

bind nand_page_seq nand_page_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ce_n_o  (ce_n_o),
  .cle_o   (cle_o),
  .ale_o   (ale_o),
  .we_n_o  (we_n_o),
  .re_n_o  (re_n_o),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o),
  .rb_i    (rb_i),
  .wid16_o (wid16_o)
);

// File: tb/nand_page_seq_tb.sv
`timescale 1ns/1ps
module nand_page_seq_tb;
  localparam int SEC = 16, PG = 64, BBM = 2, ECC = 8, MAXSEC = 4, NCS = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, write_i = 0, raw_i = 0, bus16_i = 0, big_dev_i = 0;
  logic [1:0] sectors_m1_i = 0;
  logic [23:0] page_i = 0;
  logic [0:0] cs_i = 0;
  logic busy_o, done_o, cle_o, ale_o, we_n_o, re_n_o, dq_oe_o, wid16_o;
  logic [NCS-1:0] ce_n_o;
  logic [15:0] dq_o, rd_data_o;
  logic [15:0] dq_i = 16'h0, wr_data_i = 16'h0;
  logic rb_i = 1'b1, wr_valid_i = 1'b0;
  logic wr_ready_o, rd_valid_o, ecc_phase_o;

  always #5 clk = ~clk;

  nand_page_seq #(.SECTOR_BYTES(SEC), .PAGE_BYTES(PG), .BBM_BYTES(BBM), .ECC_BYTES(ECC),
                  .MAX_SECTORS(MAXSEC), .NUM_CS(NCS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i), .raw_i(raw_i),
    .bus16_i(bus16_i), .big_dev_i(big_dev_i), .sectors_m1_i(sectors_m1_i), .page_i(page_i),
    .cs_i(cs_i), .busy_o(busy_o), .done_o(done_o), .ce_n_o(ce_n_o), .cle_o(cle_o),
    .ale_o(ale_o), .we_n_o(we_n_o), .re_n_o(re_n_o), .dq_o(dq_o), .dq_i(dq_i),
    .dq_oe_o(dq_oe_o), .rb_i(rb_i), .wid16_o(wid16_o), .wr_data_i(wr_data_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .ecc_phase_o(ecc_phase_o));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string exp_req[$];
  int cur_cs = 0;
  bit cur_b16 = 0, stall_en = 0, hs = 0;
  int src_k = 0, rd_k = 0, rb_t = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  function automatic logic [15:0] f_rd(int k);
    return 16'h5A00 + 16'(k * 259);
  endfunction
  function automatic logic [15:0] g_wr(int k);
    return 16'hC300 ^ 16'(k * 33);
  endfunction
  function automatic logic [31:0] ev(int kind, bit ecc, logic [15:0] v);
    return {4'(kind), 3'b000, ecc, 8'h00, v};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [31:0] e, string r);
    exp_q.push_back(e);
    exp_req.push_back(r);
  endtask

  task automatic pop_cmp(logic [31:0] act);
    if (exp_q.size() == 0) chk(0, "R2", "unexpected bus event", act, 0);
    else begin
      logic [31:0] e = exp_q.pop_front();
      string r = exp_req.pop_front();
      chk(act == e, r, "bus event", act, e);
    end
  endtask

  task automatic build(bit wr, bit raw, bit b16, bit big, int nm1, logic [23:0] pg);
    int k = 0;
    int n, off;
    logic [15:0] m;
    m = b16 ? 16'hFFFF : 16'h00FF;
    exp_q.delete(); exp_req.delete();
    push(ev(1, 0, wr ? 16'h80 : 16'h00), wr ? "R3" : "R2");
    push(ev(2, 0, 16'h0), "R4");
    push(ev(2, 0, 16'h0), "R4");
    push(ev(2, 0, {8'h0, pg[7:0]}), "R4");
    push(ev(2, 0, {8'h0, pg[15:8]}), "R4");
    if (big) push(ev(2, 0, {8'h0, pg[23:16]}), "R4");
    if (!wr) push(ev(1, 0, 16'h30), "R2");
    n = (nm1 + 1) * (b16 ? SEC / 2 : SEC);
    for (int i = 0; i < n; i++) begin
      if (wr) push(ev(3, 0, g_wr(k) & m), "R13");
      else    push(ev(4, 0, f_rd(k) & m), "R6");
      k++;
    end
    if (!raw) begin
      off = b16 ? (PG + BBM) / 2 : PG + BBM;
      push(ev(1, 0, wr ? 16'h85 : 16'h05), "R5");
      push(ev(2, 0, 16'(off & 255)), "R5");
      push(ev(2, 0, 16'(off >> 8)), "R5");
      if (!wr) push(ev(1, 0, 16'hE0), "R5");
      n = b16 ? ECC / 2 : ECC;
      for (int i = 0; i < n; i++) begin
        if (wr) push(ev(3, 1, g_wr(k) & m), "R7");
        else    push(ev(4, 1, f_rd(k) & m), "R7");
        k++;
      end
    end
    if (wr) push(ev(1, 0, 16'h10), "R3");
  endtask

  // bus monitor, NAND device model and write source, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (busy_o) chk(ce_n_o == ~(2'(1) << cur_cs), "R10", "chip enable", 32'(ce_n_o), 32'(~(2'(1) << cur_cs)));
      if (!rb_i) chk(we_n_o && re_n_o, "R8", "strobe while busy", {we_n_o, re_n_o}, 2'b11);
      if (!prev_we && we_n_o) begin
        int kind;
        kind = cle_o ? 1 : (ale_o ? 2 : 3);
        pop_cmp(ev(kind, ecc_phase_o, dq_o));
        if (kind == 3) chk(wid16_o == cur_b16, "R9", "data lane width", 32'(wid16_o), 32'(cur_b16));
        else           chk(!wid16_o, "R9", "byte lane on cmd/addr", 32'(wid16_o), 0);
        if (cle_o && (dq_o == 16'h30 || dq_o == 16'h10)) rb_t = 8;
      end
      if (rd_valid_o) pop_cmp(ev(4, ecc_phase_o, rd_data_o));
      if (!prev_re && re_n_o) begin
        rd_k++;
        dq_i = f_rd(rd_k);
      end
      if (rb_t > 0) rb_t--;
      rb_i = !(rb_t > 0 && rb_t <= 6);
      if (hs) src_k++;
      wr_valid_i = stall_en ? ((cyc % 4) != 1) : 1'b1;
      wr_data_i  = g_wr(src_k);
      hs = wr_valid_i && wr_ready_o;
    end
    prev_we = we_n_o;
    prev_re = re_n_o;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired act=%0d exp=%0d", cyc, 0);
    summary();
  end

  task automatic launch(bit wr, bit raw, bit b16, bit big, int nm1, logic [23:0] pg, int cs, bit stall);
    build(wr, raw, b16, big, nm1, pg);
    cur_cs = cs; cur_b16 = b16; stall_en = stall;
    src_k = 0; rd_k = 0; hs = 0; dq_i = f_rd(0);
    write_i = wr; raw_i = raw; bus16_i = b16; big_dev_i = big;
    sectors_m1_i = 2'(nm1); page_i = pg; cs_i = 1'(cs);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R12", "busy after start", 32'(busy_o), 1);
    chk(!done_o, "R12", "done single pulse", 32'(done_o), 0);
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done_o, "R12", "done seen", 32'(done_o), 1);
    chk(!busy_o, "R12", "idle with done", 32'(busy_o), 0);
    chk(rb_i, "R8", "ready at done", 32'(rb_i), 1);
    chk(exp_q.size() == 0, req, "sequence complete", 32'(exp_q.size()), 0);
  endtask

  task automatic intrude();
    repeat (12) @(negedge clk);
    write_i = 1'b1; raw_i = 1'b1; bus16_i = 1'b1; cs_i = 1'(1 - cur_cs); page_i = 24'hFFFFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R11", "start ignored busy", 32'(busy_o), 1);
    chk(ce_n_o == ~(2'(1) << cur_cs), "R11", "cs unchanged", 32'(ce_n_o), 32'(~(2'(1) << cur_cs)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && ce_n_o == 2'b11, "R1", "reset busy/done/ce", {busy_o, done_o, ce_n_o}, 4'b0011);
    chk(we_n_o && re_n_o && !cle_o && !ale_o && !dq_oe_o && !rd_valid_o, "R1", "reset pins",
        {we_n_o, re_n_o, cle_o, ale_o, dq_oe_o, rd_valid_o}, 6'b110000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && ce_n_o == 2'b11 && we_n_o && re_n_o, "R1", "idle after reset",
        {busy_o, ce_n_o, we_n_o, re_n_o}, 5'b01111);

    // read, 8-bit, small device, spare step, 2 sectors, with ignored start
    launch(0, 0, 0, 0, 1, 24'h0A1B2C, 0, 0);
    intrude();
    wait_done("R2");
    // read, 16-bit, large device, 1 sector
    @(negedge clk);
    launch(0, 0, 1, 1, 0, 24'h3C4D5E, 1, 0);
    wait_done("R2");
    // program, 8-bit, large, 4 sectors, stalled stream
    @(negedge clk);
    launch(1, 0, 0, 1, 3, 24'h7F0102, 0, 1);
    wait_done("R3");
    // program raw, 16-bit, small
    @(negedge clk);
    launch(1, 1, 1, 0, 1, 24'h00FFEE, 1, 1);
    wait_done("R7");
    // raw read, then a program started in the done cycle
    @(negedge clk);
    launch(0, 1, 0, 1, 2, 24'h123456, 1, 0);
    wait_done("R7");
    launch(1, 0, 1, 0, 0, 24'h00ABCD, 0, 1);
    wait_done("R3");
    repeat (4) @(negedge clk);
    chk(!busy_o && ce_n_o == 2'b11, "R10", "idle chip enables", {busy_o, ce_n_o}, 3'b011);
    summary();
  end
endmodule